// File: doc/BRIEF.md
# Word Serializer with Clean Start After Hold

The block turns an 8-bit parallel word into a single-wire bit stream, one bit per bit-clock cycle. It takes a new word every eighth bit-clock edge and sends words back to back without a gap. Bit 0 of each word goes out first and bit 7 goes out last.

A divided word clock runs at one eighth of the bit-clock rate and rises just after each word is taken. Upstream logic uses its rising edge to present the next word.

A hold input (`sync_hold`) clears every flip-flop at once, without waiting for a clock edge, for as long as it stays high. Leaving hold is handled in step with the clock. After the input falls, the block waits for a falling bit-clock edge. The first word is latched on the rising edge that follows. This means the stream always starts with a full-width first bit.

Top module: `word_serializer`

## Requirements
- R1: While `sync_hold` is high, `ser_bit` and `word_clk` are 0. They go to 0 at once when `sync_hold` rises, with no clock edge needed.
- R2: After `sync_hold` falls, no word is taken until a falling `bit_clk` edge has occurred. The first word is taken on the next rising edge. If hold is released just after a falling edge, the next rising edge still leaves `word_clk` low.
- R3: The word taken on a latch edge appears on `ser_bit` starting one cycle later. `par_word[0]` is valid after the edge that follows the latch edge, and `par_word[1]` through `par_word[7]` follow on the next seven edges.
- R4: Once running, a new word is taken every 8 rising edges. The stream is gap-free, so bit 7 of one word is followed directly by bit 0 of the next.
- R5: `word_clk` is 1 after the latch edge and after the three edges that follow it. It is 0 after the next four edges, which gives a period of 8 bit-clock cycles.
- R6: Changes on `par_word` between latch edges have no effect on the stream. Only the value present at the latch edge is sent.
- R7: If hold is raised in the middle of a word and then released, the stream restarts from a fresh word. Its first bit is full width, and no bits of the interrupted word are sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Bit clock; one serial bit per cycle |
| sync_hold | input | 1 | Active-high asynchronous clear; released in step with the clock |
| par_word | input | 8 | Parallel word; bit 0 is sent first |
| ser_bit | output | 1 | Serial data output |
| word_clk | output | 1 | Divided clock, bit_clk/8, rising just after each word is taken |

## Verification
Hold is released just after a rising edge, so the arming falling edge comes half a cycle later. That makes the next rising edge the latch edge. From that latch edge, `word_clk` is due to be high after edges 0 to 3 and low after edges 4 to 7. `ser_bit` carries bit i−1 of the word after edge i, for i from 1 to 8.

The bench counts every rising edge from the release and samples 2 ns after each one, which is well before the next falling edge. It compares the outputs against an index computed from that count. The late-release case counts one extra idle edge first. The mid-word hold case is sampled 1 ns after hold rises, with no clock edge in between.

// File: rtl/word_serializer_pkg.sv
package word_serializer_pkg;
    localparam int unsigned WORD_W = 8;
    localparam int unsigned POS_W  = $clog2(WORD_W);

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic             wclk;
    } seq_state_t;

    typedef struct packed {
        logic [WORD_W-1:0] shreg;
        logic              sbit;
    } shift_state_t;
endpackage

// File: rtl/ws_release.sv
module ws_release (
    input  logic clk,
    input  logic hold,
    output logic armed
);
    logic arm_d, arm_q;

    always_comb begin
        arm_d = 1'b1;
    end

    // Falling-edge flop: the first falling edge after hold leaves arms the block
    always_ff @(negedge clk or posedge hold) begin
        if (hold) arm_q <= 1'b0;
        else      arm_q <= arm_d;
    end

    assign armed = arm_q;
endmodule

// File: rtl/ws_sequencer.sv
module ws_sequencer
    import word_serializer_pkg::*;
(
    input  logic clk,
    input  logic hold,
    input  logic armed,
    output logic load,
    output logic wclk
);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(WORD_W - 1);
    localparam logic [POS_W-1:0] HALF_POS = POS_W'(WORD_W / 2);

    seq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (armed) begin
            st_d.pos  = (st_q.pos == LAST_POS) ? '0 : st_q.pos + POS_W'(1);
            st_d.wclk = (st_q.pos < HALF_POS);
        end
    end

    always_ff @(posedge clk or posedge hold) begin
        if (hold) st_q <= '0;
        else      st_q <= st_d;
    end

    assign load = armed && (st_q.pos == '0);
    assign wclk = st_q.wclk;

    // R4
    pos_step_chk: assert property (@(posedge clk) disable iff (hold)
        armed |=> (st_q.pos == (($past(st_q.pos) == LAST_POS) ? '0 : $past(st_q.pos) + POS_W'(1))));

    // R5
    wclk_rise_chk: assert property (@(posedge clk) disable iff (hold)
        load |=> wclk);

    // R5
    wclk_fall_chk: assert property (@(posedge clk) disable iff (hold)
        (armed && st_q.pos == HALF_POS) |=> !wclk);
endmodule

// File: rtl/ws_shifter.sv
module ws_shifter
    import word_serializer_pkg::*;
(
    input  logic              clk,
    input  logic              hold,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    output logic              sbit
);
    shift_state_t sh_d, sh_q;

    always_comb begin
        sh_d.sbit = sh_q.shreg[0];
        if (load) sh_d.shreg = word;
        else      sh_d.shreg = {1'b0, sh_q.shreg[WORD_W-1:1]};
    end

    always_ff @(posedge clk or posedge hold) begin
        if (hold) sh_q <= '0;
        else      sh_q <= sh_d;
    end

    assign sbit = sh_q.sbit;

    // R3
    first_bit_chk: assert property (@(posedge clk) disable iff (hold)
        load |=> ##1 (sbit == $past(word[0], 2)));
endmodule

// File: rtl/word_serializer.sv
module word_serializer
    import word_serializer_pkg::*;
(
    input  logic              bit_clk,
    input  logic              sync_hold,
    input  logic [WORD_W-1:0] par_word,
    output logic              ser_bit,
    output logic              word_clk
);
    logic armed;
    logic load;

    ws_release u_release (
        .clk   (bit_clk),
        .hold  (sync_hold),
        .armed (armed)
    );

    ws_sequencer u_seq (
        .clk   (bit_clk),
        .hold  (sync_hold),
        .armed (armed),
        .load  (load),
        .wclk  (word_clk)
    );

    ws_shifter u_shift (
        .clk   (bit_clk),
        .hold  (sync_hold),
        .load  (load),
        .word  (par_word),
        .sbit  (ser_bit)
    );

    // R2
    start_armed_chk: assert property (@(posedge bit_clk) disable iff (sync_hold)
        $rose(word_clk) |-> $past(armed));
endmodule

// File: tb/word_serializer_bench.sv
module word_serializer_bench;
    logic       bit_clk = 1'b0;
    logic       sync_hold = 1'b1;
    logic [7:0] par_word = 8'h00;
    logic       ser_bit;
    logic       word_clk;
    int         n_checks = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    word_serializer u_word_serializer (
        .bit_clk   (bit_clk),
        .sync_hold (sync_hold),
        .par_word  (par_word),
        .ser_bit   (ser_bit),
        .word_clk  (word_clk)
    );

    always #4 bit_clk = ~bit_clk;

    task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic edge_sample();
        @(posedge bit_clk);
        #2;
    endtask

    // Release hold and stream three words; optionally release late or abort mid-word
    task automatic run_words(input logic [23:0] ws, input bit late, input bit abort_mid);
        logic [7:0] w [3];
        logic [7:0] nxt;
        logic       exp_bit;
        for (int k = 0; k < 3; k++) w[k] = ws[8*k +: 8];
        sync_hold = 1'b1;
        par_word  = w[0];
        repeat (2) edge_sample();
        if (late) begin
            @(negedge bit_clk);
            #1 sync_hold = 1'b0;
            edge_sample();
            // R2: no falling edge since release yet, so no start
            check(word_clk == 1'b0, "R2 late release idle wclk", {7'd0, word_clk}, 8'h00);
        end else begin
            @(posedge bit_clk);
            #2 sync_hold = 1'b0;
        end
        for (int m = 0; m < 3; m++) begin
            nxt = (m < 2) ? w[m+1] : 8'h5A;
            for (int i = 0; i < 8; i++) begin
                edge_sample();
                check(word_clk == (i < 4), "R5 word_clk phase", {7'd0, word_clk}, {7'd0, i < 4});
                if (i == 0) exp_bit = (m == 0) ? 1'b0 : w[m-1][7];
                else        exp_bit = w[m][i-1];
                check(ser_bit == exp_bit, (i == 0 && m > 0) ? "R4 gap-free boundary" : "R3 serial bit",
                      {7'd0, ser_bit}, {7'd0, exp_bit});
                if (abort_mid && m == 0 && i == 2) begin
                    #1 sync_hold = 1'b1;
                    #1;
                    check(ser_bit == 1'b0, "R1 async clear ser_bit", {7'd0, ser_bit}, 8'h00);
                    check(word_clk == 1'b0, "R1 async clear word_clk", {7'd0, word_clk}, 8'h00);
                    return;
                end
                if (i == 0) par_word = nxt;
                if (i == 3) par_word = ~nxt;   // R6: mid-window change must not matter
                if (i == 6) par_word = nxt;
            end
        end
        edge_sample();
        check(ser_bit == w[2][7], "R6 last bit of final word", {7'd0, ser_bit}, {7'd0, w[2][7]});
    endtask

    task automatic t_reset_state();
        sync_hold = 1'b1;
        repeat (3) begin
            edge_sample();
            check(ser_bit == 1'b0, "R1 hold ser_bit", {7'd0, ser_bit}, 8'h00);
            check(word_clk == 1'b0, "R1 hold word_clk", {7'd0, word_clk}, 8'h00);
        end
    endtask

    task automatic t_resync();
        run_words({8'h00, 8'h00, 8'hFF}, 1'b0, 1'b1);
        // R7: fresh restart after mid-word hold
        run_words({8'h3C, 8'h81, 8'h96}, 1'b0, 1'b0);
    endtask

    initial begin
        t_reset_state();
        run_words({8'hC3, 8'h5A, 8'hA5}, 1'b0, 1'b0);
        run_words({8'h01, 8'h80, 8'hFE}, 1'b0, 1'b0);
        run_words({8'h7F, 8'h00, 8'hB2}, 1'b1, 1'b0);
        t_resync();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule